// File: doc/BRIEF.md
# Interrupt Register Bank Controller

This block holds a last-in first-out stack of shadow banks, each able to store a full CPU register context. A context is 19 words: general registers R0 to R14, GBR, MACH, MACL and PR. When the CPU accepts an interrupt that is allowed to use banking, it asserts a save request with the live context on the input bus. The block writes that context into the next free bank and advances an occupancy counter. A restore request takes the most recent bank off the stack and presents it on the output bus, with a one-cycle load strobe that tells the register file to take it.

Two misuse cases are caught. A save into a completely full stack with overflow reporting enabled raises an overflow pulse. A restore from an empty stack raises an underflow pulse. In both cases the counter and the stored banks stay as they were, and no load strobe is issued, so the live registers keep their values. When overflow reporting is disabled, a save into a full stack is dropped without any error and the interrupt goes on unbanked. The error pulses go to the exception sequencer.

Top module: `irq_bank_ctl`

## Requirements
- R1: After reset the bank count is 0, both error outputs are low, the load strobe is low and the context output is all zeros.
- R2: A save request while the count is below 15 stores the context bus into the bank at index count, and the count reads one higher after that clock edge.
- R3: A restore request while the count is above 0 lowers the count by one. After the same edge the context output holds the bank most recently saved and not yet restored, and the load strobe is high for exactly that one cycle.
- R4: The count saturates at 15, which means every bank is occupied.
- R5: A save request with the count at 15 and the overflow enable at 1 drives the overflow output high in the following cycle. The count stays at 15 and no stored bank changes.
- R6: A save request with the count at 15 and the overflow enable at 0 raises no error. The count stays at 15 and no stored bank changes.
- R7: A restore request with the count at 0 drives the underflow output high in the following cycle. The count stays at 0, the load strobe stays low and the context output keeps its previous value.
- R8: Each error output is a single-cycle pulse. It is low in any cycle that does not directly follow the request that caused it.
- R9: Interleaved saves and restores keep last-in first-out order. Each restore returns the newest context that has not yet been restored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| save_req | input | 1 | Push the context bus onto the stack |
| restore_req | input | 1 | Pop the newest bank onto the context output |
| ovf_en | input | 1 | Enables overflow error reporting |
| ctx_in | input | 608 | Live context, word k at bits [32k+31:32k] (k=0..14 R0-R14, 15 GBR, 16 MACH, 17 MACL, 18 PR) |
| ctx_out | output | 608 | Restored context, same word layout as ctx_in |
| ctx_load | output | 1 | One-cycle strobe: ctx_out must be written to the live registers |
| bank_cnt | output | 4 | Number of occupied banks, 0 to 15 |
| ovf_err | output | 1 | Overflow error pulse |
| unf_err | output | 1 | Underflow error pulse |

## Verification
The assertions assume that save and restore requests are never high in the same cycle. The block gives no priority between them, so a checker property flags any cycle where both are high. The directed tasks in the bench only ever raise one request per cycle, always on the falling edge, and drop it again before the next request. Overflow and underflow are reached only by filling the stack to 15 or draining it to 0. This keeps the error properties on the paths that the bench model predicts.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

   // Counter width able to hold 0..n inclusive
   function automatic int cnt_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/irq_bank_ptr.sv
module irq_bank_ptr #(
   parameter int NUM_BANKS = 15,
   parameter int CNT_W     = irq_bank_pkg::cnt_width(NUM_BANKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             save_req,
   input  logic             restore_req,
   input  logic             ovf_en,
   output logic [CNT_W-1:0] cnt,
   output logic             wr_en,
   output logic [CNT_W-1:0] wr_idx,
   output logic             rd_en,
   output logic [CNT_W-1:0] rd_idx,
   output logic             ovf_err,
   output logic             unf_err
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_BANKS);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   logic is_full;
   logic is_empty;

   assign is_full  = (cnt == FULL_CNT);
   assign is_empty = (cnt == '0);
   assign wr_en    = save_req && !is_full;
   assign rd_en    = restore_req && !is_empty;
   assign wr_idx   = cnt;
   assign rd_idx   = cnt - ONE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         ovf_err <= 1'b0;
         unf_err <= 1'b0;
      end else begin
         ovf_err <= save_req && is_full && ovf_en;
         unf_err <= restore_req && is_empty;
         if (wr_en)
            cnt <= cnt + ONE;
         else if (rd_en)
            cnt <= cnt - ONE;
      end
   end

endmodule

// File: rtl/irq_bank_store.sv
module irq_bank_store #(
   parameter int NUM_BANKS      = 15,
   parameter int CTX_W          = 608,
   parameter int CNT_W          = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_idx,
   input  logic [CTX_W-1:0] din,
   input  logic             rd_en,
   input  logic [CNT_W-1:0] rd_idx,
   output logic [CTX_W-1:0] dout,
   output logic             load
);

   logic [CTX_W-1:0] bank_q [NUM_BANKS];
   logic [CTX_W-1:0] rd_mux;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = wr_en && (wr_idx == CNT_W'(b));
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n)
               bank_q[b] <= '0;
            else if (hit)
               bank_q[b] <= din;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit)
               bank_q[b] <= din;
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (rd_idx == CNT_W'(b))
            rd_mux = bank_q[b];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout <= '0;
         load <= 1'b0;
      end else begin
         load <= rd_en;
         if (rd_en)
            dout <= rd_mux;
      end
   end

endmodule

// File: rtl/irq_bank_ctl.sv
module irq_bank_ctl #(
   parameter int NUM_BANKS      = 15,
   parameter int NUM_WORDS      = 19,
   parameter int WORD_W         = 32,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int CTX_W         = NUM_WORDS * WORD_W,
   localparam int CNT_W         = irq_bank_pkg::cnt_width(NUM_BANKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             save_req,
   input  logic             restore_req,
   input  logic             ovf_en,
   input  logic [CTX_W-1:0] ctx_in,
   output logic [CTX_W-1:0] ctx_out,
   output logic             ctx_load,
   output logic [CNT_W-1:0] bank_cnt,
   output logic             ovf_err,
   output logic             unf_err
);

   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("irq_bank_ctl: NUM_BANKS must be at least 1");
   end
   if (NUM_WORDS < 1 || WORD_W < 1) begin : g_bad_ctx
      $error("irq_bank_ctl: context shape must be non-empty");
   end

   logic             wr_en;
   logic             rd_en;
   logic [CNT_W-1:0] wr_idx;
   logic [CNT_W-1:0] rd_idx;

   irq_bank_ptr #(
      .NUM_BANKS (NUM_BANKS),
      .CNT_W     (CNT_W)
   ) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .save_req    (save_req),
      .restore_req (restore_req),
      .ovf_en      (ovf_en),
      .cnt         (bank_cnt),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .rd_en       (rd_en),
      .rd_idx      (rd_idx),
      .ovf_err     (ovf_err),
      .unf_err     (unf_err)
   );

   irq_bank_store #(
      .NUM_BANKS      (NUM_BANKS),
      .CTX_W          (CTX_W),
      .CNT_W          (CNT_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .din    (ctx_in),
      .rd_en  (rd_en),
      .rd_idx (rd_idx),
      .dout   (ctx_out),
      .load   (ctx_load)
   );

endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
   parameter int NUM_BANKS = 15,
   parameter int CNT_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             save_req,
   input logic             restore_req,
   input logic             ovf_en,
   input logic             ctx_load,
   input logic [CNT_W-1:0] bank_cnt,
   input logic             ovf_err,
   input logic             unf_err
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_BANKS);

   // input rule: one request per cycle
   req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(save_req && restore_req));

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_cnt <= FULL_CNT);

   // R2
   save_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (save_req && bank_cnt != FULL_CNT) |=> (bank_cnt == $past(bank_cnt) + CNT_W'(1)));

   // R3
   restore_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restore_req && bank_cnt != '0) |=> (ctx_load && bank_cnt == $past(bank_cnt) - CNT_W'(1)));

   // R5
   no_overflow_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (save_req && bank_cnt == FULL_CNT && ovf_en) |=> (ovf_err && bank_cnt == FULL_CNT));

   // R6
   silent_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (save_req && bank_cnt == FULL_CNT && !ovf_en) |=> (!ovf_err && bank_cnt == FULL_CNT));

   // R7
   underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restore_req && bank_cnt == '0) |=> (unf_err && !ctx_load && bank_cnt == '0));

   // R8
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |-> $past(save_req && ovf_en && bank_cnt == FULL_CNT));

   // R8
   unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf_err |-> $past(restore_req && bank_cnt == '0));

endmodule

bind irq_bank_ctl irq_bank_chk #(
   .NUM_BANKS (NUM_BANKS),
   .CNT_W     (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .save_req    (save_req),
   .restore_req (restore_req),
   .ovf_en      (ovf_en),
   .ctx_load    (ctx_load),
   .bank_cnt    (bank_cnt),
   .ovf_err     (ovf_err),
   .unf_err     (unf_err)
);

// File: tb/irq_bank_ctl_bench.sv
`timescale 1ns/1ps
module irq_bank_ctl_bench;

   localparam int NB    = 15;
   localparam int NW    = 19;
   localparam int WW    = 32;
   localparam int CW    = NW * WW;
   localparam int CNTW  = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            save_req = 1'b0;
   logic            restore_req = 1'b0;
   logic            ovf_en = 1'b0;
   logic [CW-1:0]   ctx_in = '0;
   logic [CW-1:0]   ctx_out;
   logic            ctx_load;
   logic [CNTW-1:0] bank_cnt;
   logic            ovf_err;
   logic            unf_err;

   int checks = 0;
   int failures = 0;
   int exp_cnt = 0;
   logic [CW-1:0] model [NB];
   logic [CW-1:0] last_out = '0;

   always #2 clk = ~clk;

   irq_bank_ctl u_irq_bank_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .save_req    (save_req),
      .restore_req (restore_req),
      .ovf_en      (ovf_en),
      .ctx_in      (ctx_in),
      .ctx_out     (ctx_out),
      .ctx_load    (ctx_load),
      .bank_cnt    (bank_cnt),
      .ovf_err     (ovf_err),
      .unf_err     (unf_err)
   );

   function automatic logic [CW-1:0] pat(input int seed);
      logic [CW-1:0] v;
      for (int w = 0; w < NW; w++)
         v[w*WW +: WW] = (32'(seed) << 16) ^ (32'(w) * 32'h0101_0011) ^ 32'hA5C3_0000;
      return v;
   endfunction

   task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one request cycle; results sampled 1 ns after the capturing edge
   task automatic do_save(input int seed);
      @(negedge clk);
      ctx_in = pat(seed);
      save_req = 1'b1;
      @(posedge clk);
      #1;
      save_req = 1'b0;
   endtask

   task automatic do_restore();
      @(negedge clk);
      restore_req = 1'b1;
      @(posedge clk);
      #1;
      restore_req = 1'b0;
   endtask

   task automatic idle_check(input string req);
      @(posedge clk);
      #1;
      chk(req, CW'(ovf_err), '0);
      chk(req, CW'(unf_err), '0);
      chk(req, CW'(ctx_load), '0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 cnt", CW'(bank_cnt), '0);
      chk("R1 ovf", CW'(ovf_err), '0);
      chk("R1 unf", CW'(unf_err), '0);
      chk("R1 load", CW'(ctx_load), '0);
      chk("R1 ctx", ctx_out, '0);
      @(negedge clk);
      rst_n = 1'b1;
      exp_cnt = 0;
      last_out = '0;
   endtask

   task automatic t_fill(input int base);
      while (exp_cnt < NB) begin
         do_save(base + exp_cnt);
         model[exp_cnt] = pat(base + exp_cnt);
         exp_cnt++;
         chk("R2 cnt", CW'(bank_cnt), CW'(exp_cnt));
         chk("R2 no err", CW'({ovf_err, unf_err, ctx_load}), '0);
      end
      chk("R4 full", CW'(bank_cnt), CW'(NB));
   endtask

   task automatic t_overflow(input logic en);
      @(negedge clk);
      ovf_en = en;
      do_save(999);
      chk(en ? "R5 ovf" : "R6 no ovf", CW'(ovf_err), CW'(en));
      chk(en ? "R5 cnt" : "R6 cnt", CW'(bank_cnt), CW'(NB));
      chk(en ? "R5 load" : "R6 load", CW'(ctx_load), '0);
      idle_check("R8 pulse");
      ovf_en = 1'b0;
   endtask

   task automatic t_drain(input int n);
      for (int i = 0; i < n; i++) begin
         do_restore();
         exp_cnt--;
         chk("R3 cnt", CW'(bank_cnt), CW'(exp_cnt));
         chk("R3 load", CW'(ctx_load), 1);
         chk("R3 R9 ctx", ctx_out, model[exp_cnt]);
         last_out = model[exp_cnt];
      end
   endtask

   task automatic t_underflow();
      do_restore();
      chk("R7 unf", CW'(unf_err), 1);
      chk("R7 cnt", CW'(bank_cnt), '0);
      chk("R7 load", CW'(ctx_load), '0);
      chk("R7 ctx", ctx_out, last_out);
      idle_check("R8 pulse");
   endtask

   task automatic t_interleave();
      do_save(300); model[exp_cnt] = pat(300); exp_cnt++;
      do_save(301); model[exp_cnt] = pat(301); exp_cnt++;
      t_drain(1);
      do_save(302); model[exp_cnt] = pat(302); exp_cnt++;
      do_save(303); model[exp_cnt] = pat(303); exp_cnt++;
      chk("R9 cnt", CW'(bank_cnt), CW'(exp_cnt));
      t_drain(exp_cnt);
   endtask

   initial begin
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_underflow();
      t_fill(10);
      t_overflow(1'b1);
      t_overflow(1'b0);
      t_drain(NB);
      t_underflow();
      t_interleave();
      t_underflow();
      t_fill(50);
      t_overflow(1'b1);
      t_drain(3);
      t_reset();
      t_underflow();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule